// File: doc/BRIEF.md
# Five-Source Interrupt Enable and Pending Register

This block is a single 16-bit control register that gathers five interrupt sources: external, timer 1, timer 2, asynchronous serial and synchronous serial. Each source is a level input. The block watches for a low-to-high transition on each one and records it in a pending latch for that source. A pending bit stays set until software clears it with an explicit write.

The same address has a different meaning for reads and for writes. A write loads the five enable bits from its low byte. In the same write, every 1 in the matching high-byte positions clears the pending latch of that source. A read returns the current enables in the low byte and the pending latches in the high byte. The pending latches are held apart from the write data.

The block drives one interrupt request line. This line is high while any source has both its pending bit and its enable bit set. Priority and vectoring are handled by other logic.

Top module: `irq_enclr_reg`

## Requirements
- R1: After reset, all enables and all pending bits are 0, the read value is 0x0000 and `irq_o` is low.
- R2: A write (`wr_en_i` high at a clock edge) loads enable bit i (i = 0..4) from `wr_data_i[i]`. From the next cycle, `rd_data_o[i]` returns that bit. Source order from bit 0 upward is external, timer 1, timer 2, asynchronous serial, synchronous serial.
- R3: A low-to-high transition on `src_i[i]`, seen between two consecutive clock edges, sets pending bit i. It reads back at `rd_data_o[8+i]` from the next cycle. Holding the source high does not set the bit again after it is cleared.
- R4: A write with `wr_data_i[8+i]` = 1 clears pending bit i. A 0 in that position leaves the bit unchanged.
- R5: `irq_o` is high exactly when, for some i, pending bit i and enable bit i are both 1.
- R6: If a new transition on source i and a write clearing bit i happen at the same clock edge, the transition wins and pending bit i stays set.
- R7: Read bits 5..7 and 13..15 always return 0. Write bits 5..7 and 13..15 have no effect on any enable or pending bit.
- R8: A pending bit is set by its source transition whether or not that source is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data: bits 4..0 are enables, bits 12..8 are clear strobes |
| src_i | input | 5 | Interrupt source levels, bit 0 external through bit 4 synchronous serial |
| rd_data_o | output | 16 | Read value: bits 4..0 are enables, bits 12..8 are pending |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `src_i` and the write inputs are synchronous to `clk_i` and stable around each rising edge. They also assume that a source is low when reset is released, so that no transition is hidden by reset. The stimulus changes every input only on the falling edge. It keeps all sources low through each reset, so every transition the checks depend on falls between two clock edges after reset.

// File: rtl/irq_enclr_reg.sv
module irq_enclr_reg #(
  parameter int NSRC    = 5,
  parameter int DW      = 16,
  parameter int CLR_LSB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [NSRC-1:0] src_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);

  localparam int PEND_MSB = CLR_LSB + NSRC - 1;

  logic [NSRC-1:0] en_q, pend_q, src_q;
  logic [NSRC-1:0] rise, clr;

  assign rise = src_i & ~src_q;
  assign clr  = wr_en_i ? wr_data_i[PEND_MSB:CLR_LSB] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      src_q  <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr) | rise;
      if (wr_en_i) en_q <= wr_data_i[NSRC-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[NSRC-1:0]        = en_q;
    rd_data_o[PEND_MSB:CLR_LSB] = pend_q;
  end

  assign irq_o = |(pend_q & en_q);

  p_enable_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[NSRC-1:0] == $past(wr_data_i[NSRC-1:0]));

  p_irq_needs_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rd_data_o[PEND_MSB:CLR_LSB] & rd_data_o[NSRC-1:0]) != '0);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_chk
      p_rise_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(src_i[i]) |=> rd_data_o[CLR_LSB+i]);

      p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[CLR_LSB+i] && !$rose(src_i[i])) |=> !rd_data_o[CLR_LSB+i]);

      p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[CLR_LSB+i] && !(wr_en_i && wr_data_i[CLR_LSB+i])) |=> rd_data_o[CLR_LSB+i]);

      p_event_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[CLR_LSB+i] && $rose(src_i[i])) |=> rd_data_o[CLR_LSB+i]);
    end
  endgenerate

endmodule

// File: tb/irq_enclr_reg_tb.sv
`timescale 1ns/1ps
module irq_enclr_reg_tb_top;
  logic        clk = 0, rst_n = 0, we = 0;
  logic [15:0] wd = '0;
  logic [4:0]  src = '0;
  logic [15:0] rd;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_enclr_reg dut_i (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd),
                       .src_i(src), .rd_data_o(rd), .irq_o(irq));

  // {we, wdata, src, exp_rd, exp_irq}
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 16'h001F, 5'h00, 16'h001F, 1'b0}, // R2
    {1'b0, 16'h0000, 5'h01, 16'h011F, 1'b1}, // R3 R5
    {1'b0, 16'h0000, 5'h01, 16'h011F, 1'b1}, // R3 held
    {1'b1, 16'h011F, 5'h01, 16'h001F, 1'b0}, // R4
    {1'b0, 16'h0000, 5'h01, 16'h001F, 1'b0}, // R3 no retrigger
    {1'b1, 16'h0000, 5'h06, 16'h0600, 1'b0}, // R8
    {1'b1, 16'h0004, 5'h06, 16'h0604, 1'b1}, // R5
    {1'b1, 16'h0404, 5'h06, 16'h0204, 1'b0}, // R4
    {1'b1, 16'h1F04, 5'h00, 16'h0004, 1'b0}, // R4
    {1'b1, 16'h1F04, 5'h10, 16'h1004, 1'b0}, // R6
    {1'b1, 16'hE0F0, 5'h10, 16'h1010, 1'b1}, // R7
    {1'b0, 16'h0000, 5'h18, 16'h1810, 1'b1}, // R3
    {1'b1, 16'h1000, 5'h08, 16'h0800, 1'b0}, // R4
    {1'b1, 16'h0800, 5'h00, 16'h0000, 1'b0}  // R4
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic [15:0] d, input logic [4:0] s);
    @(negedge clk);
    we = w; wd = d; src = s;
    @(negedge clk);
    we = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd", rd, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd after release", rd, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][38], VEC[k][37:22], VEC[k][21:17]);
      chk($sformatf("vec%0d rd R2-R8", k), rd, VEC[k][16:1]);
      chk($sformatf("vec%0d irq R5", k), {15'b0, irq}, {15'b0, VEC[k][0]});
    end

    for (int i = 0; i < 5; i++) begin
      step(1'b1, 16'h001F, 5'h00);
      step(1'b1, 16'h001F | (16'h0100 << i), 5'h01 << i);
      chk($sformatf("R6 bit%0d event beats clear", i), rd, 16'h001F | (16'h0100 << i));
      step(1'b1, 16'h001F | (16'h0100 << i), 5'h01 << i);
      chk($sformatf("R4 bit%0d clear", i), rd, 16'h001F);
      chk($sformatf("R5 bit%0d irq low", i), {15'b0, irq}, 16'h0000);
    end

    step(1'b0, 16'h0000, 5'h00);
    step(1'b0, 16'h0000, 5'h1F);
    chk("R8 all pending", rd, 16'h1F1F);
    step(1'b1, 16'hE0E0, 5'h1F);
    chk("R7 reserved write no effect on pend", rd[15:8], 8'h1F);
    chk("R7 reserved read zero", rd & 16'hE0E0, 16'h0000);

    @(negedge clk); src = '0;
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 mid-run reset", rd, 16'h0000);
    chk("R1 mid-run irq", {15'b0, irq}, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule